// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This unit compares two IEEE-754 operands and encodes the relation between them as a 4-bit NZCV condition nibble. It also raises an invalid-operation indication. A precision select chooses between single-precision and double-precision operands. In single precision only the low 32 bits of each 64-bit operand bus are used. A mode input selects one of two compare flavours. A quiet compare complains only about signalling NaNs. A signalling compare complains about any NaN. Both flavours produce the same flags.

The unit classifies each operand as a NaN, a signalling NaN, a zero or an ordinary value. Infinities and denormals count as ordinary values, and denormals are compared exactly. The unit then orders the operands by sign and magnitude and maps the relation to a flag code. A request is presented with `in_valid`. The flags and the exception bit are registered and appear one clock later with `out_valid`. They hold their value until the next request.

Top module: `fcmp_flag_unit`

## Requirements
- R1: When the operands are equal, `nzcv` is 4'b0110. The bit order is N=bit3, Z=bit2, C=bit1, V=bit0, so Z and C are set and N and V are clear.
- R2: When operand A is less than operand B, `nzcv` is 4'b1000 (only N set).
- R3: When operand A is greater than operand B, `nzcv` is 4'b0010 (only C set).
- R4: The result is unordered, and `nzcv` is 4'b0011 (C and V set), when either operand is a NaN. A NaN has an exponent field of all ones and a nonzero fraction.
- R5: With `prec_dbl`=0 the operands are binary32 values in bits [31:0], and bits [63:32] have no effect on any output. With `prec_dbl`=1 the operands are full binary64 values.
- R6: With `sig_mode`=0 (quiet), `invalid` is 1 exactly when at least one operand is a signalling NaN. A NaN is signalling when the most significant fraction bit is 0.
- R7: With `sig_mode`=1 (signalling), `invalid` is 1 exactly when at least one operand is a NaN of either kind. The `nzcv` value is the same as in quiet mode.
- R8: Positive zero and negative zero compare as equal in any combination.
- R9: The ordering uses sign and magnitude. Any negative nonzero value is below any positive nonzero value. When both operands are negative, a larger magnitude is the smaller value. Infinities are the extremes, and denormals are ordered exactly.
- R10: The results appear on the clock edge after the one that samples `in_valid`=1, with `out_valid` high for that one cycle. When `in_valid` is low, `nzcv` and `invalid` keep their values. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compare request this cycle |
| prec_dbl | input | 1 | 1 selects binary64, 0 selects binary32 in the low bits |
| sig_mode | input | 1 | 1 selects the signalling compare, 0 the quiet compare |
| op_a | input | 64 | Operand A |
| op_b | input | 64 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after the request |
| nzcv | output | 4 | Condition nibble {N,Z,C,V} |
| invalid | output | 1 | Invalid-operation exception indication |

## Verification
Every result is due exactly one clock edge after the edge that samples the request. The bench drives a request at a falling edge and samples `nzcv`, `invalid` and `out_valid` at the next falling edge. It then drops `in_valid` and samples again one cycle later to confirm that the flags are held and `out_valid` has fallen. The sweep covers every pair from a 16-entry table of special values, for both precisions and both modes. The table holds signed zeros, denormals, normals, extremes, infinities and both NaN kinds. Expected flags come from a numeric rank assigned to each table entry.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
   typedef enum logic [1:0] {
      REL_EQ = 2'd0,
      REL_LT = 2'd1,
      REL_GT = 2'd2,
      REL_UN = 2'd3
   } fcmp_rel_e;

   localparam logic [3:0] NZCV_EQ = 4'b0110;
   localparam logic [3:0] NZCV_LT = 4'b1000;
   localparam logic [3:0] NZCV_GT = 4'b0010;
   localparam logic [3:0] NZCV_UN = 4'b0011;
endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int MAG_W  = 63,
   localparam int WORD_W = EXP_W + FRAC_W + 1
) (
   input  logic [WORD_W-1:0] word,
   output logic              sign,
   output logic              is_nan,
   output logic              is_snan,
   output logic              is_zero,
   output logic [MAG_W-1:0]  mag
);
   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;

   assign sign    = word[WORD_W-1];
   assign exp_f   = word[WORD_W-2 -: EXP_W];
   assign frac_f  = word[FRAC_W-1:0];
   assign is_nan  = (&exp_f) && (|frac_f);
   assign is_snan = is_nan && !frac_f[FRAC_W-1];
   assign is_zero = ~|word[WORD_W-2:0];
   assign mag     = MAG_W'(word[WORD_W-2:0]);
endmodule

// File: rtl/fcmp_order.sv
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int MAG_W = 63
) (
   input  logic             sign_a,
   input  logic             sign_b,
   input  logic             zero_a,
   input  logic             zero_b,
   input  logic             nan_any,
   input  logic [MAG_W-1:0] mag_a,
   input  logic [MAG_W-1:0] mag_b,
   output fcmp_rel_e        rel
);
   logic mag_lt;
   logic mag_eq;

   assign mag_lt = mag_a < mag_b;
   assign mag_eq = mag_a == mag_b;

   always_comb begin
      if (nan_any)                 rel = REL_UN;
      else if (zero_a && zero_b)   rel = REL_EQ;
      else if (sign_a != sign_b)   rel = sign_a ? REL_LT : REL_GT;
      else if (mag_eq)             rel = REL_EQ;
      else if (mag_lt ^ sign_a)    rel = REL_LT;
      else                         rel = REL_GT;
   end
endmodule

// File: rtl/fcmp_flag_map.sv
module fcmp_flag_map
   import fcmp_pkg::*;
(
   input  fcmp_rel_e   rel,
   output logic [3:0]  flags
);
   always_comb begin
      unique case (rel)
         REL_EQ:  flags = NZCV_EQ;
         REL_LT:  flags = NZCV_LT;
         REL_GT:  flags = NZCV_GT;
         default: flags = NZCV_UN;
      endcase
   end
endmodule

// File: rtl/fcmp_flag_unit.sv
module fcmp_flag_unit
   import fcmp_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int SP_EXP  = 8,
   parameter int SP_FRAC = 23,
   parameter int DP_EXP  = 11,
   parameter int DP_FRAC = 52
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              prec_dbl,
   input  logic              sig_mode,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   output logic              out_valid,
   output logic [3:0]        nzcv,
   output logic              invalid
);
   localparam int SP_W  = SP_EXP + SP_FRAC + 1;
   localparam int DP_W  = DP_EXP + DP_FRAC + 1;
   localparam int MAG_W = DP_W - 1;
   localparam int N_OP  = 2;

   generate
      if (SP_W > DATA_W || DP_W > DATA_W) begin : g_bad_width
         $error("operand format wider than data bus");
      end
      if (SP_W >= DP_W) begin : g_bad_order
         $error("single format must be narrower than double format");
      end
   endgenerate

   logic [DATA_W-1:0] ops [N_OP];
   logic [N_OP-1:0]   sp_sign, sp_nan, sp_snan, sp_zero;
   logic [N_OP-1:0]   dp_sign, dp_nan, dp_snan, dp_zero;
   logic [MAG_W-1:0]  sp_mag [N_OP];
   logic [MAG_W-1:0]  dp_mag [N_OP];
   logic [N_OP-1:0]   sel_sign, sel_nan, sel_snan, sel_zero;
   logic [MAG_W-1:0]  sel_mag [N_OP];

   assign ops[0] = op_a;
   assign ops[1] = op_b;

   for (genvar i = 0; i < N_OP; i++) begin : g_op
      fcmp_classify #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC), .MAG_W(MAG_W)) i_cls_sp (
         .word    (ops[i][SP_W-1:0]),
         .sign    (sp_sign[i]),
         .is_nan  (sp_nan[i]),
         .is_snan (sp_snan[i]),
         .is_zero (sp_zero[i]),
         .mag     (sp_mag[i])
      );
      fcmp_classify #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC), .MAG_W(MAG_W)) i_cls_dp (
         .word    (ops[i][DP_W-1:0]),
         .sign    (dp_sign[i]),
         .is_nan  (dp_nan[i]),
         .is_snan (dp_snan[i]),
         .is_zero (dp_zero[i]),
         .mag     (dp_mag[i])
      );
      assign sel_sign[i] = prec_dbl ? dp_sign[i] : sp_sign[i];
      assign sel_nan[i]  = prec_dbl ? dp_nan[i]  : sp_nan[i];
      assign sel_snan[i] = prec_dbl ? dp_snan[i] : sp_snan[i];
      assign sel_zero[i] = prec_dbl ? dp_zero[i] : sp_zero[i];
      assign sel_mag[i]  = prec_dbl ? dp_mag[i]  : sp_mag[i];
   end

   fcmp_rel_e  rel;
   logic [3:0] flags_nx;
   logic       inv_nx;

   fcmp_order #(.MAG_W(MAG_W)) i_order (
      .sign_a  (sel_sign[0]),
      .sign_b  (sel_sign[1]),
      .zero_a  (sel_zero[0]),
      .zero_b  (sel_zero[1]),
      .nan_any (|sel_nan),
      .mag_a   (sel_mag[0]),
      .mag_b   (sel_mag[1]),
      .rel     (rel)
   );

   fcmp_flag_map i_map (
      .rel   (rel),
      .flags (flags_nx)
   );

   assign inv_nx = sig_mode ? (|sel_nan) : (|sel_snan);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         nzcv      <= 4'b0000;
         invalid   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            nzcv    <= flags_nx;
            invalid <= inv_nx;
         end
      end
   end
endmodule

// File: rtl/fcmp_flag_chk.sv
module fcmp_flag_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              prec_dbl,
   input logic              sig_mode,
   input logic [DATA_W-1:0] op_a,
   input logic [DATA_W-1:0] op_b,
   input logic              out_valid,
   input logic [3:0]        nzcv,
   input logic              invalid
);
   logic a_dp_nan;
   logic a_dp_zero;
   logic b_dp_zero;
   assign a_dp_nan  = (op_a[62:52] == 11'h7ff) && (op_a[51:0] != 52'd0);
   assign a_dp_zero = op_a[62:0] == 63'd0;
   assign b_dp_zero = op_b[62:0] == 63'd0;

   // R1
   eq_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && prec_dbl && op_a == op_b && !a_dp_nan) |=> nzcv == 4'b0110);

   // R4
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (nzcv == 4'b0110 || nzcv == 4'b1000 ||
                     nzcv == 4'b0010 || nzcv == 4'b0011));

   // R6
   inv_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && invalid) |-> nzcv == 4'b0011);

   // R7
   sig_nan_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && sig_mode && prec_dbl && a_dp_nan) |=> invalid);

   // R8
   zero_eq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && prec_dbl && a_dp_zero && b_dp_zero) |=> (nzcv == 4'b0110 && !invalid));

   // R10
   valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(nzcv) && $stable(invalid)));
endmodule

bind fcmp_flag_unit fcmp_flag_chk #(.DATA_W(DATA_W)) i_fcmp_flag_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .prec_dbl  (prec_dbl),
   .sig_mode  (sig_mode),
   .op_a      (op_a),
   .op_b      (op_b),
   .out_valid (out_valid),
   .nzcv      (nzcv),
   .invalid   (invalid)
);

// File: tb/test_fcmp_flag_unit.sv
`timescale 1ns/1ps
module test_fcmp_flag_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        prec_dbl = 1'b0;
   logic        sig_mode = 1'b0;
   logic [63:0] op_a = '0;
   logic [63:0] op_b = '0;
   logic        out_valid;
   logic [3:0]  nzcv;
   logic        invalid;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 0;

   always #2.5 clk = ~clk;

   fcmp_flag_unit i_fcmp_flag_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .prec_dbl(prec_dbl),
      .sig_mode(sig_mode), .op_a(op_a), .op_b(op_b),
      .out_valid(out_valid), .nzcv(nzcv), .invalid(invalid)
   );

   // table entry: value, kind (0 number, 1 quiet NaN, 2 signalling NaN), rank
   function automatic logic [63:0] tval(input bit dbl, input int k);
      logic [31:0] s;
      logic [63:0] d;
      case (k)
         0:  begin s = 32'hff800000; d = 64'hfff0000000000000; end
         1:  begin s = 32'hff7fffff; d = 64'hffefffffffffffff; end
         2:  begin s = 32'hc0000000; d = 64'hc000000000000000; end
         3:  begin s = 32'hbf800000; d = 64'hbff0000000000000; end
         4:  begin s = 32'h80000001; d = 64'h8000000000000001; end
         5:  begin s = 32'h80000000; d = 64'h8000000000000000; end
         6:  begin s = 32'h00000000; d = 64'h0000000000000000; end
         7:  begin s = 32'h00000001; d = 64'h0000000000000001; end
         8:  begin s = 32'h3f800000; d = 64'h3ff0000000000000; end
         9:  begin s = 32'h3fc00000; d = 64'h3ff8000000000000; end
         10: begin s = 32'h7f7fffff; d = 64'h7fefffffffffffff; end
         11: begin s = 32'h7f800000; d = 64'h7ff0000000000000; end
         12: begin s = 32'h7fc00000; d = 64'h7ff8000000000000; end
         13: begin s = 32'h7f800001; d = 64'h7ff0000000000001; end
         14: begin s = 32'hffc00001; d = 64'hfff8000000000001; end
         default: begin s = 32'hff900000; d = 64'hfff4000000000000; end
      endcase
      return dbl ? d : {32'hA5C3_0000 | 32'(k * 7919), s};
   endfunction

   function automatic int tkind(input int k);
      if (k == 12 || k == 14) return 1;
      if (k == 13 || k == 15) return 2;
      return 0;
   endfunction

   function automatic int trank(input int k);
      return (k <= 5) ? k : k - 1;   // both zeros share one rank
   endfunction

   task automatic check(input string tag, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_fails++;
         $display("FAIL R10 watchdog: actual 1 expected 0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10", "reset out_valid", 64'(out_valid), 64'd0);
      check("R10", "reset nzcv", 64'(nzcv), 64'd0);
      check("R10", "reset invalid", 64'(invalid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 16; i++) begin
               for (int j = 0; j < 16; j++) begin
                  logic [3:0] en;
                  logic       ei;
                  string      rt;
                  string      it;
                  int ki, kj;
                  ki = tkind(i);
                  kj = tkind(j);
                  if (ki != 0 || kj != 0) begin
                     en = 4'b0011; rt = "R4";
                  end else if (trank(i) == trank(j)) begin
                     en = 4'b0110; rt = (i == 5 || i == 6) ? "R8" : "R1";
                  end else if (trank(i) < trank(j)) begin
                     en = 4'b1000; rt = (i < 5 && j < 5) ? "R9" : "R2";
                  end else begin
                     en = 4'b0010; rt = (i < 5 && j < 5) ? "R9" : "R3";
                  end
                  if (m == 1) begin
                     ei = (ki != 0) || (kj != 0); it = "R7";
                  end else begin
                     ei = (ki == 2) || (kj == 2); it = "R6";
                  end
                  if (p == 0) rt = (i == 3 && j == 8) ? "R5" : rt;
                  prec_dbl = p[0];
                  sig_mode = m[0];
                  op_a     = tval(p[0], i);
                  op_b     = tval(p[0], j);
                  in_valid = 1'b1;
                  @(negedge clk);
                  check("R10", "out_valid", 64'(out_valid), 64'd1);
                  check(rt, "nzcv", 64'(nzcv), 64'(en));
                  check(it, "invalid", 64'(invalid), 64'(ei));
                  in_valid = 1'b0;
                  op_a = ~op_a;
                  op_b = 64'd0;
                  @(negedge clk);
                  if (j == 0) begin
                     check("R10", "held out_valid", 64'(out_valid), 64'd0);
                     check("R10", "held nzcv", 64'(nzcv), 64'(en));
                     check("R10", "held invalid", 64'(invalid), 64'(ei));
                  end
               end
            end
         end
      end
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule